// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small programmable logic device rebuilt out of ordinary registers. A configuration vector is shifted in one bit per clock. It sets which literals each product term connects to, how the terms are summed onto outputs, and how each output cell behaves. The product terms take each literal in true or complemented form. A literal is either a dedicated data input or the value of an output cell.

A build-time mode picks the OR-plane scheme. In shared mode a connection matrix lets any term reach any output. In fixed mode each output ORs only its own contiguous group of terms, so a term that two outputs need must be built twice. Each output cell can pass its sum through a D flip-flop and can invert the result. It also has an enable for its pin driver. When the driver is off, the pin value is read back as a literal, so the pin works as an extra input. When the driver is on, the cell's own value is fed back, so one output can be built from another, such as a carry.

Top module: `sop_array`

## Requirements
- R1: While `cfgLoad` is high and `rst` is low, each rising edge shifts `cfgBit` into bit 0 of the configuration vector and moves every other bit up by one, so the bits go in most significant first. While `cfgLoad` is low, the configuration holds its value whatever `cfgBit` does.
- R2: `rst` is synchronous. It clears the whole configuration and every output flip-flop, and it wins over `cfgLoad` when both are high in the same cycle. While `rst` is high `pinOe` is all 0, and after reset `pinOut` is all 0.
- R3: Literal l is `dataIn[l]` for l < NUM_IN, and the cell literal of macrocell l-NUM_IN above that. For term t, the true-literal connection is configuration bit 2*NL*t+2*l and the complement connection is the next bit up, where NL = NUM_IN+NUM_MC. A term with no connection at all evaluates to 0, even if it is routed to an output.
- R4: In shared mode, bit AND_W + t*NUM_MC + m routes term t to output m, where AND_W = 2*NL*NUM_TERMS. One term can feed several outputs.
- R5: In fixed mode, output m is the OR of terms m*G through m*G+G-1, where G = NUM_TERMS/NUM_MC. The configuration carries no OR-plane bits.
- R6: The 3-bit control word of macrocell m starts at bit CTRL_BASE+3*m, where CTRL_BASE is the end of the OR-plane field. Bit 0 is the driver enable, bit 1 is invert and bit 2 selects the flip-flop. While `cfgLoad` is high `pinOe` is all 0; otherwise `pinOe[m]` follows the driver enable.
- R7: The cell literal of macrocell m is the macrocell's own pre-driver value when `pinOe[m]` is 1, and `pinIn[m]` otherwise. `pinIn[m]` has no effect while that pin drives.
- R8: Each macrocell's flip-flop captures the cell's OR sum on every rising edge. With the flip-flop selected, the output changes only at the edge.
- R9: `pinOut[m]` is the selected value (flip-flop or OR sum) XORed with the invert bit, so polarity is applied after the register.
- R10: A value fed back from a driving macrocell reaches the terms of other macrocells in the same cycle, so chained functions settle combinationally, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfgLoad | input | 1 | Shift enable for the configuration chain |
| cfgBit | input | 1 | Serial configuration data |
| dataIn | input | NUM_IN | Dedicated logic inputs |
| pinIn | input | NUM_MC | Value sensed on each macrocell pin |
| pinOut | output | NUM_MC | Macrocell output value (driver data) |
| pinOe | output | NUM_MC | Driver enable for each macrocell pin |

## Verification
Two events can fall in the same cycle, and the bench provokes each of them. First, the bench drives reset together with a load of one-bits. It then judges the result at the pins: every output and every enable must read 0, with no trace of the shifted bits. Second, within one registered test it changes the inputs so that a combinational output sharing the same product term responds at once. The registered, inverted output beside it must keep its old value until the next edge.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;

  localparam int MODE_SHARED = 0;
  localparam int MODE_FIXED  = 1;
  localparam int MC_CTRL_W   = 3;

  // Strobes from the control path to the datapath.
  typedef struct packed {
    logic shiftEn;
    logic clearAll;
    logic driveEn;
  } strobes_t;

  // Per-macrocell control word, bit 0 = driver enable.
  typedef struct packed {
    logic regSel;
    logic invert;
    logic outEn;
  } mcCtrl_t;

  function automatic int cfgWidth(input int ni, input int nm, input int nt, input int mode);
    return nt * 2 * (ni + nm) + ((mode == MODE_SHARED) ? nt * nm : 0) + MC_CTRL_W * nm;
  endfunction

endpackage

// File: rtl/sop_ctrl.sv
`timescale 1ns/1ps
module sop_ctrl
  import sop_pkg::*;
(
  input  logic     rst,
  input  logic     cfgLoad,
  output strobes_t strobes
);

  // Reset wins over loading; drivers stay off while loading or in reset.
  always_comb begin
    strobes.clearAll = rst;
    strobes.shiftEn  = cfgLoad & ~rst;
    strobes.driveEn  = ~cfgLoad & ~rst;
  end

endmodule

// File: rtl/sop_cfg_chain.sv
`timescale 1ns/1ps
module sop_cfg_chain #(
  parameter int CFG_W = 64
) (
  input  logic             clk,
  input  logic             shiftEn,
  input  logic             clear,
  input  logic             cfgBit,
  output logic [CFG_W-1:0] cfgVec
);

  always_ff @(posedge clk) begin
    if (clear)        cfgVec <= '0;
    else if (shiftEn) cfgVec <= {cfgVec[CFG_W-2:0], cfgBit};
  end

  // R1: one shift per enabled edge, new bit enters at the bottom
  p_shift_order_r1: assert property (@(posedge clk) disable iff (clear)
    shiftEn |=> (cfgVec == {$past(cfgVec[CFG_W-2:0]), $past(cfgBit)}));

  // R1: configuration holds while not loading
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (clear)
    !shiftEn |=> $stable(cfgVec));

endmodule

// File: rtl/sop_planes.sv
`timescale 1ns/1ps
module sop_planes
  import sop_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_MC    = 6,
  parameter int NUM_TERMS = 24,
  parameter int MODE      = MODE_SHARED,
  localparam int CFG_W    = cfgWidth(NUM_IN, NUM_MC, NUM_TERMS, MODE)
) (
  input  logic              clk,
  input  logic              clearAll,
  input  logic              driveEn,
  input  logic [CFG_W-1:0]  cfgVec,
  input  logic [NUM_IN-1:0] dataIn,
  input  logic [NUM_MC-1:0] pinIn,
  output logic [NUM_MC-1:0] pinOut,
  output logic [NUM_MC-1:0] pinOe
);

  localparam int NL        = NUM_IN + NUM_MC;
  localparam int AND_W     = NUM_TERMS * 2 * NL;
  localparam int OR_W      = (MODE == MODE_SHARED) ? NUM_TERMS * NUM_MC : 0;
  localparam int CTRL_BASE = AND_W + OR_W;
  localparam int GRP       = NUM_TERMS / NUM_MC;

  logic [NL-1:0]        litVec;
  logic [NUM_TERMS-1:0] termVal;
  logic [NUM_MC-1:0]    orSum;
  logic [NUM_MC-1:0]    regQ;
  logic [NUM_MC-1:0]    mcVal;

  assign litVec[NUM_IN-1:0] = dataIn;

  // AND plane
  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    logic [NL-1:0] useTrue;
    logic [NL-1:0] useComp;
    always_comb begin
      for (int l = 0; l < NL; l++) begin
        useTrue[l] = cfgVec[t*2*NL + 2*l];
        useComp[l] = cfgVec[t*2*NL + 2*l + 1];
      end
    end
    assign termVal[t] = (|{useTrue, useComp})
                      & (&(~useTrue | litVec))
                      & (&(~useComp | ~litVec));

    // R3: a term without any connection never asserts
    p_empty_term_r3: assert property (@(posedge clk) disable iff (clearAll)
      ({useTrue, useComp} == '0) |-> !termVal[t]);
  end

  // OR plane, variant picked by MODE
  if (MODE == MODE_SHARED) begin : g_shared
    for (genvar m = 0; m < NUM_MC; m++) begin : g_out
      logic [NUM_TERMS-1:0] route;
      always_comb begin
        for (int t = 0; t < NUM_TERMS; t++) route[t] = cfgVec[AND_W + t*NUM_MC + m];
      end
      assign orSum[m] = |(route & termVal);
    end
  end else begin : g_fixed
    for (genvar m = 0; m < NUM_MC; m++) begin : g_out
      assign orSum[m] = |termVal[m*GRP +: GRP];
    end
  end

  // Macrocells
  always_ff @(posedge clk) begin
    if (clearAll) regQ <= '0;
    else          regQ <= orSum;
  end

  for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
    mcCtrl_t ctl;
    assign ctl       = mcCtrl_t'(cfgVec[CTRL_BASE + MC_CTRL_W*m +: MC_CTRL_W]);
    assign mcVal[m]  = (ctl.regSel ? regQ[m] : orSum[m]) ^ ctl.invert;
    assign pinOe[m]  = ctl.outEn & driveEn;
    assign litVec[NUM_IN + m] = pinOe[m] ? mcVal[m] : pinIn[m];

    // R7: a driving pin feeds its own value back, not the sensed pin
    p_feedback_src_r7: assert property (@(posedge clk) disable iff (clearAll)
      pinOe[m] |-> (litVec[NUM_IN + m] == pinOut[m]));
  end

  assign pinOut = mcVal;

  // R2: flip-flops are empty on the first cycle after reset
  p_reg_cleared_r2: assert property (@(posedge clk) disable iff (clearAll)
    $past(clearAll) |-> (regQ == '0));

endmodule

// File: rtl/sop_array.sv
`timescale 1ns/1ps
module sop_array
  import sop_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_MC    = 6,
  parameter int NUM_TERMS = 24,
  parameter int MODE      = MODE_SHARED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgLoad,
  input  logic              cfgBit,
  input  logic [NUM_IN-1:0] dataIn,
  input  logic [NUM_MC-1:0] pinIn,
  output logic [NUM_MC-1:0] pinOut,
  output logic [NUM_MC-1:0] pinOe
);

  localparam int CFG_W = cfgWidth(NUM_IN, NUM_MC, NUM_TERMS, MODE);

  strobes_t         strobes;
  logic [CFG_W-1:0] cfgVec;

  sop_ctrl i_ctrl (
    .rst     (rst),
    .cfgLoad (cfgLoad),
    .strobes (strobes)
  );

  sop_cfg_chain #(.CFG_W(CFG_W)) i_chain (
    .clk     (clk),
    .shiftEn (strobes.shiftEn),
    .clear   (strobes.clearAll),
    .cfgBit  (cfgBit),
    .cfgVec  (cfgVec)
  );

  sop_planes #(
    .NUM_IN    (NUM_IN),
    .NUM_MC    (NUM_MC),
    .NUM_TERMS (NUM_TERMS),
    .MODE      (MODE)
  ) i_planes (
    .clk      (clk),
    .clearAll (strobes.clearAll),
    .driveEn  (strobes.driveEn),
    .cfgVec   (cfgVec),
    .dataIn   (dataIn),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe)
  );

  // R6: no pin is driven while configuration is shifting
  p_no_drive_in_load_r6: assert property (@(posedge clk) disable iff (rst)
    cfgLoad |-> (pinOe == '0));

endmodule

// File: tb/test_sop_array.sv
`timescale 1ns/1ps
module test_sop_array;
  import sop_pkg::*;

  localparam int NI    = 4;
  localparam int NM    = 6;
  localparam int NT    = 24;
  localparam int NL    = NI + NM;
  localparam int G     = NT / NM;
  localparam int AND_W = NT * 2 * NL;
  localparam int ORW_S = NT * NM;
  localparam int CFG_S = cfgWidth(NI, NM, NT, MODE_SHARED);
  localparam int CFG_F = cfgWidth(NI, NM, NT, MODE_FIXED);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadS = 1'b0, loadF = 1'b0, bitS = 1'b0, bitF = 1'b0;
  logic [NI-1:0] dataIn = '0;
  logic [NM-1:0] pinIn  = '0;
  logic [NM-1:0] outS, oeS, outF, oeF;

  always #10 clk = ~clk;

  sop_array #(.NUM_IN(NI), .NUM_MC(NM), .NUM_TERMS(NT), .MODE(MODE_SHARED)) i_sop_array (
    .clk(clk), .rst(rst), .cfgLoad(loadS), .cfgBit(bitS),
    .dataIn(dataIn), .pinIn(pinIn), .pinOut(outS), .pinOe(oeS));

  sop_array #(.NUM_IN(NI), .NUM_MC(NM), .NUM_TERMS(NT), .MODE(MODE_FIXED)) i_sop_array_fixed (
    .clk(clk), .rst(rst), .cfgLoad(loadF), .cfgBit(bitF),
    .dataIn(dataIn), .pinIn(pinIn), .pinOut(outF), .pinOe(oeF));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [CFG_S-1:0] cfgS;
  logic [CFG_F-1:0] cfgF;
  int nextS;
  int nextF [NM];

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [NL-1:0] litBit(input int i);
    return NL'(1) << i;
  endfunction

  task automatic clearCfg();
    cfgS = '0;
    cfgF = '0;
    nextS = 0;
    for (int m = 0; m < NM; m++) nextF[m] = 0;
  endtask

  // Adds one product term for output 'out' to both configurations.
  task automatic addTerm(input int out, input logic [NL-1:0] tm, input logic [NL-1:0] cm);
    int tf;
    tf = out * G + nextF[out];
    for (int l = 0; l < NL; l++) begin
      cfgS[nextS*2*NL + 2*l]     = tm[l];
      cfgS[nextS*2*NL + 2*l + 1] = cm[l];
      cfgF[tf*2*NL + 2*l]        = tm[l];
      cfgF[tf*2*NL + 2*l + 1]    = cm[l];
    end
    cfgS[AND_W + nextS*NM + out] = 1'b1;
    nextS++;
    nextF[out]++;
  endtask

  task automatic addPair(input int out, input int x, input int y);
    addTerm(out, litBit(x) | litBit(y), '0);
  endtask

  // Odd-parity function of three literals as four minterms.
  task automatic addParity(input int out, input int x, input int y, input int z);
    int pats [4] = '{1, 2, 4, 7};
    for (int k = 0; k < 4; k++) begin
      logic [NL-1:0] tm, cm;
      tm = '0; cm = '0;
      if (pats[k][0]) tm |= litBit(x); else cm |= litBit(x);
      if (pats[k][1]) tm |= litBit(y); else cm |= litBit(y);
      if (pats[k][2]) tm |= litBit(z); else cm |= litBit(z);
      addTerm(out, tm, cm);
    end
  endtask

  task automatic setCtrl(input int m, input logic [2:0] c);
    cfgS[AND_W + ORW_S + 3*m +: 3] = c;
    cfgF[AND_W + 3*m +: 3]         = c;
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic loadBoth();
    for (int i = CFG_S - 1; i >= 0; i--) begin
      loadS = 1'b1;
      bitS  = cfgS[i];
      loadF = (i < CFG_F);
      bitF  = (i < CFG_F) ? cfgF[i] : 1'b0;
      if (i == CFG_S - 2) begin
        #1;
        check("R6", "no drive while loading", 32'(oeS), 32'd0);
      end
      @(negedge clk);
    end
    loadS = 1'b0;
    loadF = 1'b0;
  endtask

  function automatic logic [1:0] enc3(input int d);
    return (d == 2) ? 2'b10 : 2'(d);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // Reset state
    repeat (3) @(negedge clk);
    #1;
    check("R2", "pinOe in reset", 32'({oeS, oeF}), 32'd0);
    check("R2", "pinOut after reset", 32'({outS, outF}), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // Two-bit ripple adder: A0=in0 B0=in1 A1=in2 B1=in3, carry in on pin 4
    clearCfg();
    addParity(0, 0, 1, NI + 4);
    addPair(1, 0, 1); addPair(1, 0, NI + 4); addPair(1, 1, NI + 4);
    addParity(2, 2, 3, NI + 1);
    addPair(3, 2, 3); addPair(3, 2, NI + 1); addPair(3, 3, NI + 1);
    cfgS[AND_W + 23*NM + 5] = 1'b1;   // empty term routed to output 5
    for (int m = 0; m < 4; m++) setCtrl(m, 3'b001);
    loadBoth();
    // cfgBit activity with load low must not disturb the configuration
    for (int k = 0; k < 20; k++) begin
      bitS = ~bitS; bitF = ~bitF;
      @(negedge clk);
    end
    #1;
    check("R1", "config held, shared", 32'(oeS), 32'h0F);
    check("R1", "config held, fixed", 32'(oeF), 32'h0F);
    check("R6", "enables after load", 32'({oeS, oeF}), 32'h3CF);

    for (int v = 0; v < 32; v++) begin
      int a, b, s, c0;
      logic [3:0] exp;
      dataIn = v[3:0];
      pinIn  = {1'b0, v[4], ~v[3:0]};   // driving pins see wrong values
      #1;
      a  = v[0] + 2 * v[2];
      b  = v[1] + 2 * v[3];
      s  = a + b + v[4];
      c0 = (v[0] + v[1] + v[4]) / 2;
      exp = {s[2], s[1], c0[0], s[0]};
      check("R10", "adder shared", 32'(outS[3:0]), 32'(exp));
      check("R10", "adder fixed", 32'(outF[3:0]), 32'(exp));
      check("R7", "pinIn ignored on driven pins", 32'({outS[3:0], outF[3:0]}), 32'({exp, exp}));
      check("R3", "empty term gives 0", 32'({outS[5], outF[5]}), 32'd0);
      @(negedge clk);
    end

    // Base-3 digit multiplier: a={in1,in0}, b={in3,in2}
    pinIn = '0;
    clearCfg();
    addPair(0, 1, 3); addPair(0, 0, 2);
    addPair(1, 1, 2); addPair(1, 0, 3);
    addPair(2, 1, 3);
    for (int m = 0; m < 4; m++) setCtrl(m, 3'b001);
    loadBoth();
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        int p;
        logic [3:0] exp;
        dataIn = {enc3(b), enc3(a)};
        #1;
        p = a * b;
        exp = {enc3(p / 3), enc3(p % 3)};
        check("R4", "multiplier shared terms", 32'(outS[3:0]), 32'(exp));
        check("R5", "multiplier fixed groups", 32'(outF[3:0]), 32'(exp));
        @(negedge clk);
      end
    end

    // Registered inverted cell 0 and combinational cell 1 on the same product
    clearCfg();
    addPair(0, 0, 1);
    cfgS[AND_W + 0*NM + 1] = 1'b1;      // shared: term 0 also to output 1
    cfgF[(G*2*NL) + 0] = 1'b1;          // fixed: own copy in group 1
    cfgF[(G*2*NL) + 2] = 1'b1;
    setCtrl(0, 3'b111);
    setCtrl(1, 3'b001);
    dataIn = '0;
    loadBoth();
    @(negedge clk);
    #1;
    check("R9", "inverted register holding 0", 32'({outS[0], outF[0]}), 32'h3);
    check("R4", "shared product low", 32'({outS[1], outF[1]}), 32'h0);
    dataIn = 4'b0011;
    #1;
    check("R4", "shared product follows input", 32'({outS[1], outF[1]}), 32'h3);
    check("R8", "register waits for edge", 32'({outS[0], outF[0]}), 32'h3);
    @(negedge clk);
    #1;
    check("R8", "register captured at edge", 32'({outS[0], outF[0]}), 32'h0);
    check("R9", "polarity after register", 32'({outS[1], outF[1]}), 32'h3);

    // Reset and load in the same cycle: reset wins
    rst = 1'b1; loadS = 1'b1; loadF = 1'b1; bitS = 1'b1; bitF = 1'b1;
    @(negedge clk);
    rst = 1'b0; loadS = 1'b0; loadF = 1'b0;
    dataIn = 4'b1111;
    pinIn  = '1;
    #1;
    check("R2", "reset over load, enables", 32'({oeS, oeF}), 32'd0);
    check("R2", "reset over load, outputs", 32'({outS, outF}), 32'd0);

    finishRun();
  end

endmodule